// File: doc/BRIEF.md
# Three-Cycle DMA Break Sequencer

This block is a DMA engine that sits beside a small processor and takes memory cycles away from it for an I/O device. A device raises a break request. With it, the device gives the direction of the transfer, the word to store, and either a channel base location or, in one-cycle mode, a target address of its own. The channel's bookkeeping lives in memory, not in the device. The even base location holds the word count as a negative two's-complement number, and the next location holds the current transfer address.

In three-cycle mode the sequencer makes three memory cycles for each word, in a fixed order:
1. It reads the count, adds one and writes it back.
2. It reads the address, adds one and writes it back.
3. It moves the data word at that incremented address.

Software therefore seeds the address cell with one less than the first buffer location. When the incremented count reaches zero, the completion pulse of that word also carries a done flag.

In one-cycle mode the device keeps its own address and count, so only the data cycle touches memory. This gives three times the word rate. The processor is held off through a stall output for the whole of each sequence.

Top module: `dma_break_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `cpu_stall`, `mem_req`, `brk_ack` and `brk_done` are all low.
- R2: A request is accepted only when the sequencer is idle. `cpu_stall` is high from the cycle after acceptance up to and including the completion cycle, and low in the idle cycle that follows.
- R3: In three-cycle mode the memory handshakes for one word are exactly five, in this order:
  - a read of the count cell (the base with bit 0 forced to 0);
  - a write of that value plus one to the count cell;
  - a read of the address cell (the base with bit 0 forced to 1);
  - a write of that value plus one to the address cell;
  - the data access at the incremented address.
  Bit 0 of `brk_base` has no effect.
- R4: `brk_to_mem`=1 makes the data access a write of `brk_wdata`. `brk_to_mem`=0 makes it a read, and the word read is presented on `brk_rdata` in the completion cycle.
- R5: In three-cycle mode `brk_done` is high with `brk_ack` exactly when the incremented count is zero. Both the count and the address wrap modulo 2^12, so 7777 octal plus one is 0.
- R6: With `brk_one_cycle`=1 the sequencer makes exactly one handshake per word, the data access at `brk_addr`. It touches no count or address cell and keeps `brk_done` low.
- R7: A memory request holds its address, write enable and write data unchanged until `mem_ack`. Read data is taken from `mem_rdata` one cycle after the accepting `mem_ack`.
- R8: `brk_ack` is high for exactly one cycle. That cycle is the one after the data handshake.
- R9: Request fields are captured when the request is accepted. Changes to them during a sequence have no effect on that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| brk_req | input | 1 | Break request from the device, level |
| brk_one_cycle | input | 1 | 1: device supplies the address, data cycle only |
| brk_to_mem | input | 1 | 1: device word to memory; 0: memory word to device |
| brk_base | input | AW | Channel base location; bit 0 ignored |
| brk_addr | input | AW | Target address in one-cycle mode |
| brk_wdata | input | DW | Word to store |
| brk_ack | output | 1 | One-cycle completion pulse |
| brk_done | output | 1 | Count reached zero with this word |
| brk_rdata | output | DW | Word read for the device, valid with brk_ack |
| cpu_stall | output | 1 | Holds the processor off memory |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the request this cycle |
| mem_rdata | input | DW | Read data, one cycle after acknowledge |

## Verification
A wrong sequencer state shows up at the memory port in the very next handshake. The scoreboard compares each accepted access against the expected address, direction and data, so a skipped phase, a swapped order or a stray access is reported at the edge where it happens. A bad incrementer or a wrong capture register shows up one handshake later, as a wrong write-back value or a wrong data address. A wrong done flag or a wrong stall span appears in the completion cycle of that same word. The memory acknowledge is delayed on some cycles, so any hold or latch fault meets a waiting request.

// File: rtl/dmab_pkg.sv
package dmab_pkg;

   // sequencer phases; counter phases are read, latch, write-back
   typedef enum logic [3:0] {
      ST_IDLE    = 4'd0,
      ST_CNT_RD  = 4'd1,
      ST_CNT_LAT = 4'd2,
      ST_CNT_WR  = 4'd3,
      ST_ADR_RD  = 4'd4,
      ST_ADR_LAT = 4'd5,
      ST_ADR_WR  = 4'd6,
      ST_XFER    = 4'd7,
      ST_FIN     = 4'd8
   } seq_state_t;

   function automatic logic is_mem_phase(input seq_state_t s);
      return (s == ST_CNT_RD) || (s == ST_CNT_WR) || (s == ST_ADR_RD) ||
             (s == ST_ADR_WR) || (s == ST_XFER);
   endfunction

   function automatic logic is_count_phase(input seq_state_t s);
      return (s == ST_CNT_RD) || (s == ST_CNT_LAT) || (s == ST_CNT_WR);
   endfunction

   function automatic logic is_addr_phase(input seq_state_t s);
      return (s == ST_ADR_RD) || (s == ST_ADR_LAT) || (s == ST_ADR_WR);
   endfunction

endpackage

// File: rtl/dmab_fsm.sv
module dmab_fsm
   import dmab_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       brk_req,
   input  logic       one_sel,
   input  logic       mem_ack,
   output logic       accept,
   output seq_state_t state
);

   seq_state_t state_nx;

   assign accept = (state == ST_IDLE) && brk_req;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:    if (brk_req) state_nx = one_sel ? ST_XFER : ST_CNT_RD;
         ST_CNT_RD:  if (mem_ack) state_nx = ST_CNT_LAT;
         ST_CNT_LAT: state_nx = ST_CNT_WR;
         ST_CNT_WR:  if (mem_ack) state_nx = ST_ADR_RD;
         ST_ADR_RD:  if (mem_ack) state_nx = ST_ADR_LAT;
         ST_ADR_LAT: state_nx = ST_ADR_WR;
         ST_ADR_WR:  if (mem_ack) state_nx = ST_XFER;
         ST_XFER:    if (mem_ack) state_nx = ST_FIN;
         ST_FIN:     state_nx = ST_IDLE;
         default:    state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

endmodule

// File: rtl/dmab_regs.sv
module dmab_regs
   import dmab_pkg::*;
#(
   parameter int AW           = 12,
   parameter int DW           = 12,
   parameter bit ONE_CYCLE_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  seq_state_t    state,
   input  logic          accept,
   input  logic          brk_one_cycle,
   input  logic          brk_to_mem,
   input  logic [AW-1:0] brk_base,
   input  logic [AW-1:0] brk_addr,
   input  logic [DW-1:0] brk_wdata,
   input  logic [DW-1:0] mem_rdata,
   output logic          one_sel,
   output logic          one_q,
   output logic          to_mem_q,
   output logic [AW-1:0] cnt_loc,
   output logic [AW-1:0] adr_loc,
   output logic [AW-1:0] dev_addr_q,
   output logic [DW-1:0] data_q,
   output logic [DW-1:0] wc_q,
   output logic [DW-1:0] ca_q,
   output logic          count_zero
);

   localparam logic [DW-1:0] WORD_ONE = DW'(1);

   logic [AW-2:0] base_hi_q;
   logic          unused_base_lsb;

   assign unused_base_lsb = brk_base[0];

   // parameter picks whether the one-cycle flag is honoured
   generate
      if (ONE_CYCLE_EN) begin : g_one_on
         assign one_sel = brk_one_cycle;
      end else begin : g_one_off
         logic unused_one_flag;
         assign unused_one_flag = brk_one_cycle;
         assign one_sel         = 1'b0;
      end
   endgenerate

   // request capture: fields frozen at acceptance
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         one_q      <= 1'b0;
         to_mem_q   <= 1'b0;
         base_hi_q  <= '0;
         dev_addr_q <= '0;
         data_q     <= '0;
      end else if (accept) begin
         one_q      <= one_sel;
         to_mem_q   <= brk_to_mem;
         base_hi_q  <= brk_base[AW-1:1];
         dev_addr_q <= brk_addr;
         data_q     <= brk_wdata;
      end
   end

   assign cnt_loc = {base_hi_q, 1'b0};
   assign adr_loc = {base_hi_q, 1'b1};

   // counter cells: read data arrives in the latch phase, stored incremented
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wc_q <= '0;
         ca_q <= '0;
      end else begin
         if (state == ST_CNT_LAT) wc_q <= mem_rdata + WORD_ONE;
         if (state == ST_ADR_LAT) ca_q <= mem_rdata + WORD_ONE;
      end
   end

   assign count_zero = (wc_q == '0);

endmodule

// File: rtl/dmab_memport.sv
module dmab_memport
   import dmab_pkg::*;
#(
   parameter int AW = 12,
   parameter int DW = 12
)(
   input  seq_state_t    state,
   input  logic          one_q,
   input  logic          to_mem_q,
   input  logic [AW-1:0] cnt_loc,
   input  logic [AW-1:0] adr_loc,
   input  logic [AW-1:0] dev_addr_q,
   input  logic [DW-1:0] data_q,
   input  logic [DW-1:0] wc_q,
   input  logic [DW-1:0] ca_q,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata
);

   logic [AW-1:0] xfer_addr;
   logic [AW-1:0] ca_as_addr;

   // address word may be wider than the address bus
   generate
      if (DW > AW) begin : g_trunc
         logic unused_ca_hi;
         assign unused_ca_hi = ^ca_q[DW-1:AW];
         assign ca_as_addr   = ca_q[AW-1:0];
      end else begin : g_exact
         assign ca_as_addr = ca_q[AW-1:0];
      end
   endgenerate

   assign xfer_addr = one_q ? dev_addr_q : ca_as_addr;
   assign mem_req   = is_mem_phase(state);

   always_comb begin
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      if (is_count_phase(state)) begin
         mem_addr = cnt_loc;
         if (state == ST_CNT_WR) begin
            mem_we    = 1'b1;
            mem_wdata = wc_q;
         end
      end else if (is_addr_phase(state)) begin
         mem_addr = adr_loc;
         if (state == ST_ADR_WR) begin
            mem_we    = 1'b1;
            mem_wdata = ca_q;
         end
      end else if (state == ST_XFER) begin
         mem_addr  = xfer_addr;
         mem_we    = to_mem_q;
         mem_wdata = to_mem_q ? data_q : '0;
      end
   end

endmodule

// File: rtl/dma_break_seq.sv
module dma_break_seq
   import dmab_pkg::*;
#(
   parameter int AW           = 12,
   parameter int DW           = 12,
   parameter bit ONE_CYCLE_EN = 1'b1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          brk_req,
   input  logic          brk_one_cycle,
   input  logic          brk_to_mem,
   input  logic [AW-1:0] brk_base,
   input  logic [AW-1:0] brk_addr,
   input  logic [DW-1:0] brk_wdata,
   output logic          brk_ack,
   output logic          brk_done,
   output logic [DW-1:0] brk_rdata,
   output logic          cpu_stall,
   output logic          mem_req,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   input  logic          mem_ack,
   input  logic [DW-1:0] mem_rdata
);

   generate
      if (AW < 2) begin : g_bad_aw
         $error("dma_break_seq: AW must be at least 2");
      end
      if (DW < AW) begin : g_bad_dw
         $error("dma_break_seq: DW must hold a full address");
      end
   endgenerate

   seq_state_t    state;
   logic          accept;
   logic          one_sel;
   logic          one_q;
   logic          to_mem_q;
   logic [AW-1:0] cnt_loc;
   logic [AW-1:0] adr_loc;
   logic [AW-1:0] dev_addr_q;
   logic [DW-1:0] data_q;
   logic [DW-1:0] wc_q;
   logic [DW-1:0] ca_q;
   logic          count_zero;

   dmab_fsm u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .brk_req (brk_req),
      .one_sel (one_sel),
      .mem_ack (mem_ack),
      .accept  (accept),
      .state   (state)
   );

   dmab_regs #(.AW(AW), .DW(DW), .ONE_CYCLE_EN(ONE_CYCLE_EN)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .state         (state),
      .accept        (accept),
      .brk_one_cycle (brk_one_cycle),
      .brk_to_mem    (brk_to_mem),
      .brk_base      (brk_base),
      .brk_addr      (brk_addr),
      .brk_wdata     (brk_wdata),
      .mem_rdata     (mem_rdata),
      .one_sel       (one_sel),
      .one_q         (one_q),
      .to_mem_q      (to_mem_q),
      .cnt_loc       (cnt_loc),
      .adr_loc       (adr_loc),
      .dev_addr_q    (dev_addr_q),
      .data_q        (data_q),
      .wc_q          (wc_q),
      .ca_q          (ca_q),
      .count_zero    (count_zero)
   );

   dmab_memport #(.AW(AW), .DW(DW)) u_mem (
      .state      (state),
      .one_q      (one_q),
      .to_mem_q   (to_mem_q),
      .cnt_loc    (cnt_loc),
      .adr_loc    (adr_loc),
      .dev_addr_q (dev_addr_q),
      .data_q     (data_q),
      .wc_q       (wc_q),
      .ca_q       (ca_q),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata)
   );

   // completion cycle is the one where data-cycle read data is on mem_rdata
   assign brk_ack   = (state == ST_FIN);
   assign brk_done  = brk_ack && !one_q && count_zero;
   assign brk_rdata = (brk_ack && !to_mem_q) ? mem_rdata : '0;
   assign cpu_stall = (state != ST_IDLE);

endmodule

// File: rtl/dmab_sva.sv
module dmab_sva #(
   parameter int AW = 12,
   parameter int DW = 12
)(
   input logic          clk,
   input logic          rst_n,
   input logic          brk_req,
   input logic          brk_ack,
   input logic          brk_done,
   input logic          cpu_stall,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ack
);

   a_r2_req_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_stall);

   a_r2_stall_from_request: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_stall) |-> $past(brk_req));

   a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                                 $stable(mem_we) && $stable(mem_wdata)));

   a_r8_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ack |=> !brk_ack);

   a_r8_ack_after_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(brk_ack) |-> $past(mem_req && mem_ack));

   a_r5_done_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
      brk_done |-> brk_ack);

   a_r2_idle_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      brk_ack |=> !cpu_stall);

endmodule

bind dma_break_seq dmab_sva #(.AW(AW), .DW(DW)) u_sva (
   .clk       (clk),
   .rst_n     (rst_n),
   .brk_req   (brk_req),
   .brk_ack   (brk_ack),
   .brk_done  (brk_done),
   .cpu_stall (cpu_stall),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .mem_ack   (mem_ack)
);

// File: tb/dma_break_seq_test.sv
module dma_break_seq_test;

   localparam int AW = 12;
   localparam int DW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          brk_req = 1'b0;
   logic          brk_one_cycle = 1'b0;
   logic          brk_to_mem = 1'b0;
   logic [AW-1:0] brk_base = '0;
   logic [AW-1:0] brk_addr = '0;
   logic [DW-1:0] brk_wdata = '0;
   logic          brk_ack;
   logic          brk_done;
   logic [DW-1:0] brk_rdata;
   logic          cpu_stall;
   logic          mem_req;
   logic          mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_ack = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   always #2.5 clk = ~clk;

   dma_break_seq #(.AW(AW), .DW(DW)) uut (.*);

   int errs = 0;
   int checks = 0;
   int hs_cnt = 0;
   int cyc = 0;
   logic [1:0] ack_ctr = '0;
   logic [DW-1:0] mem_model [int];

   typedef struct {
      logic          we;
      logic [AW-1:0] addr;
      logic [DW-1:0] wdata;
   } acc_t;
   acc_t exp_q [$];

   function automatic logic [DW-1:0] rd(input logic [AW-1:0] a);
      return mem_model.exists(int'(a)) ? mem_model[int'(a)] : (a ^ 12'o5252);
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s %s: actual=%0o expected=%0o", req, what, act, expv);
      end
   endtask

   // memory model: acknowledge pattern with waits, one-cycle read latency
   always @(negedge clk) begin
      ack_ctr <= ack_ctr + 2'd1;
      mem_ack <= mem_req && (ack_ctr != 2'd1);
   end

   always @(posedge clk) begin
      if (mem_req && mem_ack) begin
         if (mem_we) mem_model[int'(mem_addr)] = mem_wdata;
         else        mem_rdata <= rd(mem_addr);
      end
   end

   // monitor: every accepted access is compared with the scoreboard front
   always @(posedge clk) begin
      cyc++;
      if (rst_n && mem_req && mem_ack) begin
         hs_cnt++;
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3", "unexpected access addr", 32'(mem_addr), 32'hFFFF);
         end else begin
            acc_t e;
            e = exp_q.pop_front();
            chk(mem_we == e.we, "R3", "access direction", 32'(mem_we), 32'(e.we));
            chk(mem_addr == e.addr, "R3", "access address", 32'(mem_addr), 32'(e.addr));
            if (e.we)
               chk(mem_wdata == e.wdata, "R4", "write data", 32'(mem_wdata), 32'(e.wdata));
         end
      end
   end

   // driver: pushes the expected accesses, then runs one word
   task automatic xfer(input bit one, input bit to_mem, input logic [AW-1:0] base,
                       input logic [AW-1:0] daddr, input logic [DW-1:0] wdat,
                       input bit perturb, input bit exp_done_in, input string tag);
      logic [AW-1:0] cl, al, tgt;
      logic [DW-1:0] wc, ca, exp_rd;
      bit exp_done;
      int n;
      acc_t it;
      if (!one) begin
         cl = {base[AW-1:1], 1'b0};
         al = {base[AW-1:1], 1'b1};
         wc = rd(cl) + 12'd1;
         ca = rd(al) + 12'd1;
         it = '{1'b0, cl, '0}; exp_q.push_back(it);
         it = '{1'b1, cl, wc}; exp_q.push_back(it);
         it = '{1'b0, al, '0}; exp_q.push_back(it);
         it = '{1'b1, al, ca}; exp_q.push_back(it);
         tgt = ca[AW-1:0];
         exp_done = (wc == '0);
      end else begin
         tgt = daddr;
         exp_done = 1'b0;
      end
      chk(exp_done == exp_done_in, tag, "bench plan of done", 32'(exp_done), 32'(exp_done_in));
      exp_rd = rd(tgt);
      it = '{to_mem, tgt, wdat}; exp_q.push_back(it);
      hs_cnt = 0;
      @(negedge clk);
      brk_req = 1'b1; brk_one_cycle = one; brk_to_mem = to_mem;
      brk_base = base; brk_addr = daddr; brk_wdata = wdat;
      n = 0;
      @(negedge clk);
      if (perturb) begin
         brk_to_mem = ~to_mem; brk_base = base ^ 12'o0100;
         brk_addr = daddr ^ 12'o0007; brk_wdata = ~wdat; brk_one_cycle = ~one;
      end
      while (!brk_ack && n < 100) begin
         chk(cpu_stall == 1'b1, "R2", "stall during sequence", 32'(cpu_stall), 32'd1);
         n++;
         @(negedge clk);
      end
      chk(brk_ack == 1'b1, "R8", "completion seen", 32'(brk_ack), 32'd1);
      chk(cpu_stall == 1'b1, "R2", "stall in completion cycle", 32'(cpu_stall), 32'd1);
      chk(hs_cnt == (one ? 1 : 5), one ? "R6" : "R3", "handshakes per word",
          32'(hs_cnt), one ? 32'd1 : 32'd5);
      chk(brk_done == exp_done, one ? "R6" : "R5", "done flag", 32'(brk_done), 32'(exp_done));
      if (!to_mem)
         chk(brk_rdata == exp_rd, "R4", "read word to device", 32'(brk_rdata), 32'(exp_rd));
      chk(exp_q.size() == 0, "R3", "scoreboard drained", 32'(exp_q.size()), 32'd0);
      brk_req = 1'b0;
      @(negedge clk);
      chk(brk_ack == 1'b0, "R8", "ack single cycle", 32'(brk_ack), 32'd0);
      chk(cpu_stall == 1'b0, "R2", "idle after completion", 32'(cpu_stall), 32'd0);
   endtask

   initial begin : watchdog
      wait (cyc > 20000);
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin : main
      repeat (3) @(negedge clk);
      chk(cpu_stall == 0 && mem_req == 0 && brk_ack == 0 && brk_done == 0,
          "R1", "outputs in reset", {28'd0, cpu_stall, mem_req, brk_ack, brk_done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cpu_stall == 0 && mem_req == 0 && brk_ack == 0 && brk_done == 0,
          "R1", "outputs after reset", {28'd0, cpu_stall, mem_req, brk_ack, brk_done}, 32'd0);

      // R3 R4 R5 R7: three-word input block, count -3, buffer at 0400
      mem_model[int'(12'o0020)] = 12'o7775;
      mem_model[int'(12'o0021)] = 12'o0377;
      xfer(0, 1, 12'o0020, '0, 12'o1234, 0, 0, "R4");
      xfer(0, 1, 12'o0020, '0, 12'o4321, 0, 0, "R4");
      xfer(0, 1, 12'o0020, '0, 12'o7070, 0, 1, "R5");
      chk(rd(12'o0400) == 12'o1234, "R4", "stored word 0", 32'(rd(12'o0400)), 32'o1234);
      chk(rd(12'o0402) == 12'o7070, "R4", "stored word 2", 32'(rd(12'o0402)), 32'o7070);
      chk(rd(12'o0020) == 12'o0000, "R5", "count cell at end", 32'(rd(12'o0020)), 32'o0);
      chk(rd(12'o0021) == 12'o0402, "R3", "address cell at end", 32'(rd(12'o0021)), 32'o0402);

      // R3 odd base ignored, R4 R7 output block of two
      mem_model[int'(12'o0030)] = 12'o7776;
      mem_model[int'(12'o0031)] = 12'o0477;
      mem_model[int'(12'o0500)] = 12'o6543;
      mem_model[int'(12'o0501)] = 12'o0017;
      xfer(0, 0, 12'o0031, '0, 12'o0000, 0, 0, "R7");
      xfer(0, 0, 12'o0031, '0, 12'o0000, 0, 1, "R5");

      // R5 wrap: count -1 and address 7777 -> data at 0000
      mem_model[int'(12'o0040)] = 12'o7777;
      mem_model[int'(12'o0041)] = 12'o7777;
      xfer(0, 1, 12'o0040, '0, 12'o2525, 0, 1, "R5");
      chk(rd(12'o0000) == 12'o2525, "R5", "wrapped address store", 32'(rd(12'o0000)), 32'o2525);

      // R9 fields changed mid-sequence
      mem_model[int'(12'o0050)] = 12'o7770;
      mem_model[int'(12'o0051)] = 12'o1077;
      xfer(0, 1, 12'o0050, '0, 12'o3333, 1, 0, "R9");
      chk(rd(12'o1100) == 12'o3333, "R9", "captured data stored", 32'(rd(12'o1100)), 32'o3333);

      // R6 one-cycle mode: writes and a read, counters untouched
      xfer(1, 1, 12'o0050, 12'o2000, 12'o0101, 0, 0, "R6");
      xfer(1, 1, 12'o0050, 12'o2001, 12'o0202, 0, 0, "R6");
      mem_model[int'(12'o2002)] = 12'o7654;
      xfer(1, 0, 12'o0050, 12'o2002, 12'o0000, 1, 0, "R6");
      chk(rd(12'o0050) == 12'o7771, "R6", "count cell untouched", 32'(rd(12'o0050)), 32'o7771);
      chk(rd(12'o2001) == 12'o0202, "R6", "one-cycle store", 32'(rd(12'o2001)), 32'o0202);

      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

endmodule